// File: doc/BRIEF.md
# Hardware LIFO Register Stack

This block is a last-in first-out store made of registers. It has a fixed depth of 2^PTR_W words, which is 64 at the default setting. A stack pointer that wraps around selects the top word. Two single-bit flags report whether the stack is full or empty. A client pushes a word by raising `push_req` with the value on `push_data`. It removes the top word by raising `pop_req`. The removed word is loaded into the registered output `pop_data` at the same clock edge.

The pointer is moved before a push writes and after a pop reads. From reset, the first word therefore goes to address 1 and the last word goes to address 0. No depth comparator is used. The stack is full when a push brings the pointer back to zero. It is empty when a pop brings the pointer back to zero. Any request that cannot be served leaves every piece of state as it was and produces a one-cycle `err` pulse. This covers a push while full, a pop while empty, and a push and a pop in the same cycle.

Top module: `regstack_top`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, `full` is 0, `empty` is 1, `err` is 0 and `pop_data` is 0.
- R2: Words come out in reverse push order. A legal pop returns the most recently pushed word that has not yet been popped.
- R3: Starting empty, `full` stays 0 after each of the first 63 legal pushes and becomes 1 after the 64th. `full` and `empty` are never 1 together.
- R4: A legal push clears `empty`. A legal pop that removes the last stored word sets `empty`.
- R5: A legal pop clears `full`.
- R6: A push while `full` is 1 stores nothing and changes no flag. It makes `err` 1 for exactly the cycle after the request.
- R7: A pop while `empty` is 1 leaves `pop_data` and the flags unchanged and makes `err` 1 for the cycle after the request.
- R8: A push and a pop requested in the same cycle are illegal. Nothing changes, and `err` is 1 in the following cycle.
- R9: `pop_data` takes the popped word at the clock edge that accepts the pop. It holds that value until the next legal pop.
- R10: The pointer wraps modulo 64. After the stack has been filled completely and drained, further pushes and pops behave exactly as from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to place `push_data` on top |
| push_data | input | DATA_W | Word to be pushed |
| pop_req | input | 1 | Request to remove the top word |
| pop_data | output | DATA_W | Last popped word, registered |
| full | output | 1 | All 64 words occupied |
| empty | output | 1 | No word stored |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The hardest condition to reach is the boundary where the pointer has wrapped all the way around. This is the 64th push, which lands at address 0 and raises `full`, followed by a refused push that must not overwrite that word. The bench reaches it by filling the stack completely with distinct, index-tagged words. It then attempts one more push, and drains all 64 entries while checking each word against its index. A damaged slot 0 or slot 1 is therefore caught. Further pushes and pops after the drain show that the wrapped pointer is back in its starting state.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

   // Decoded request class for one cycle
   typedef enum logic [1:0] {
      REQ_IDLE = 2'd0,
      REQ_PUSH = 2'd1,
      REQ_POP  = 2'd2,
      REQ_BAD  = 2'd3
   } req_e;

endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
   import regstack_pkg::*;
(
   input  logic push_req,
   input  logic pop_req,
   input  logic full,
   input  logic empty,
   output req_e kind
);

   always_comb begin
      kind = REQ_IDLE;
      if (push_req && pop_req)      kind = REQ_BAD;
      else if (push_req)            kind = full  ? REQ_BAD : REQ_PUSH;
      else if (pop_req)             kind = empty ? REQ_BAD : REQ_POP;
   end

endmodule

// File: rtl/regstack_ptr.sv
module regstack_ptr
   import regstack_pkg::*;
#(
   parameter int PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  req_e             kind,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] ptr_up,
   output logic             full,
   output logic             empty
);

   logic [PTR_W-1:0] ptr_dn;

   // Pointer keeps only PTR_W bits: arithmetic wraps naturally
   assign ptr_up = ptr + 1'b1;
   assign ptr_dn = ptr - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         full  <= 1'b0;
         empty <= 1'b1;
      end else begin
         unique case (kind)
            REQ_PUSH: begin
               ptr   <= ptr_up;
               full  <= (ptr_up == '0);
               empty <= 1'b0;
            end
            REQ_POP: begin
               ptr   <= ptr_dn;
               empty <= (ptr_dn == '0);
               full  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/regstack_mem.sv
module regstack_mem #(
   parameter int DATA_W = 16,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << PTR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata = words[raddr];

endmodule

// File: rtl/regstack_top.sv
module regstack_top
   import regstack_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PTR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   output logic              full,
   output logic              empty,
   output logic              err
);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regstack_top: DATA_W must be at least 1");
      end
      if (PTR_W < 1 || PTR_W > 10) begin : g_bad_ptr
         $error("regstack_top: PTR_W must lie in 1..10");
      end
   endgenerate

   req_e              kind;
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  ptr_up;
   logic [DATA_W-1:0] top_word;

   regstack_ctrl i_ctrl (
      .push_req (push_req),
      .pop_req  (pop_req),
      .full     (full),
      .empty    (empty),
      .kind     (kind)
   );

   regstack_ptr #(.PTR_W(PTR_W)) i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind   (kind),
      .ptr    (ptr),
      .ptr_up (ptr_up),
      .full   (full),
      .empty  (empty)
   );

   // Push writes at the incremented pointer; pop reads at the current one
   regstack_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_mem (
      .clk   (clk),
      .we    (kind == REQ_PUSH),
      .waddr (ptr_up),
      .wdata (push_data),
      .raddr (ptr),
      .rdata (top_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data <= '0;
         err      <= 1'b0;
      end else begin
         err <= (kind == REQ_BAD);
         if (kind == REQ_POP) pop_data <= top_word;
      end
   end

endmodule

// File: rtl/regstack_chk.sv
module regstack_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic              pop_req,
   input logic [DATA_W-1:0] pop_data,
   input logic              full,
   input logic              empty,
   input logic              err
);

   assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_push_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req && !full) |=> !empty);

   assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && !empty) |=> !full);

   assert_full_push_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req && full) |=> (err && full && !empty));

   assert_empty_pop_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && empty) |=> (err && empty && $stable(pop_data)));

   assert_both_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop_req) |=> (err && $stable(full) && $stable(empty) && $stable(pop_data)));

   assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_req && !push_req && !empty) |=> $stable(pop_data));

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(push_req && pop_req) && !(push_req && full) && !(pop_req && empty)) |=> !err);

endmodule

bind regstack_top regstack_chk #(.DATA_W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .push_req (push_req),
   .pop_req  (pop_req),
   .pop_data (pop_data),
   .full     (full),
   .empty    (empty),
   .err      (err)
);

// File: tb/test_regstack_top.sv
`timescale 1ns/1ps
module test_regstack_top;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data;
   logic          full, empty, err;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   regstack_top #(.DATA_W(DW), .PTR_W(6)) i_regstack_top (
      .clk (clk), .rst_n (rst_n),
      .push_req (push_req), .push_data (push_data),
      .pop_req (pop_req), .pop_data (pop_data),
      .full (full), .empty (empty), .err (err)
   );

   typedef struct packed {
      logic          push;
      logic          pop;
      logic [DW-1:0] data;
      logic          x_full;
      logic          x_empty;
      logic          x_err;
      logic [DW-1:0] x_out;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 16'h0000},  // R4 push clears empty
      '{1'b1, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 16'h0000},
      '{1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h2222},  // R2 R9 last in first out
      '{1'b1, 1'b1, 16'h3333, 1'b0, 1'b0, 1'b1, 16'h2222},  // R8 both requests
      '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h2222},  // R9 hold
      '{1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h1111},  // R4 last pop sets empty
      '{1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h1111},  // R7 pop while empty
      '{1'b1, 1'b0, 16'h4444, 1'b0, 1'b0, 1'b0, 16'h1111},
      '{1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h4444},
      '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h4444}
   };

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic pu, input logic po, input logic [DW-1:0] d);
      @(negedge clk);
      push_req  = pu;
      pop_req   = po;
      push_data = d;
      @(posedge clk);
      #1;
      push_req = 1'b0;
      pop_req  = 1'b0;
   endtask

   function automatic logic [DW-1:0] tag(input int i);
      return 16'hC300 | 16'(i);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state while reset is held and at the first edge after release
      #7;
      chk("R1 full",  {15'd0, full},  16'd0);
      chk("R1 empty", {15'd0, empty}, 16'd1);
      chk("R1 err",   {15'd0, err},   16'd0);
      chk("R1 data",  pop_data,       16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 empty after release", {15'd0, empty}, 16'd1);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         step(VECS[v].push, VECS[v].pop, VECS[v].data);
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d full", v),  {15'd0, full},  {15'd0, VECS[v].x_full});
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d empty", v), {15'd0, empty}, {15'd0, VECS[v].x_empty});
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d err", v),   {15'd0, err},   {15'd0, VECS[v].x_err});
         chk($sformatf("R2/R4/R7/R8/R9 vec%0d data", v),  pop_data,       VECS[v].x_out);
      end

      // R3 fill to capacity
      for (int i = 0; i < 64; i++) begin
         step(1'b1, 1'b0, tag(i));
         chk($sformatf("R3 full after push %0d", i + 1), {15'd0, full}, {15'd0, (i == 63)});
         chk("R4 not empty while filling", {15'd0, empty}, 16'd0);
      end

      // R6 push while full is refused, error for one cycle
      step(1'b1, 1'b0, 16'hDEAD);
      chk("R6 err on full push", {15'd0, err},  16'd1);
      chk("R6 still full",       {15'd0, full}, 16'd1);
      chk("R6 data unchanged",   pop_data,      16'h4444);
      step(1'b0, 1'b0, 16'h0);
      chk("R6 err is one cycle", {15'd0, err},  16'd0);

      // R2 R5 drain: every word back in reverse order, slot 0 intact
      for (int i = 63; i >= 0; i--) begin
         step(1'b0, 1'b1, 16'h0);
         chk($sformatf("R2 pop word %0d", i), pop_data, tag(i));
         chk("R5 full cleared by pop", {15'd0, full}, 16'd0);
         chk($sformatf("R4 empty after pop %0d", i), {15'd0, empty}, {15'd0, (i == 0)});
      end

      // R7 pop on empty after a wrap
      step(1'b0, 1'b1, 16'h0);
      chk("R7 err on empty pop", {15'd0, err}, 16'd1);
      chk("R7 data held",        pop_data,     tag(0));

      // R10 behaves as from reset after a full wrap
      step(1'b1, 1'b0, 16'h1234);
      step(1'b1, 1'b0, 16'h5678);
      step(1'b0, 1'b1, 16'h0);
      chk("R10 top after wrap",  pop_data, 16'h5678);
      step(1'b0, 1'b1, 16'h0);
      chk("R10 next after wrap", pop_data, 16'h1234);
      chk("R10 empty after wrap", {15'd0, empty}, 16'd1);

      // R1 reset in mid-use
      step(1'b1, 1'b0, 16'h9999);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 empty on reset", {15'd0, empty}, 16'd1);
      chk("R1 data on reset",  pop_data,       16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 16'h0);
      chk("R1 pop after reset refused", {15'd0, err}, 16'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule